// File: doc/BRIEF.md
# Low-Frequency Oscillator Start-Up and Clock Control

This block is the digital side of a slow crystal oscillator. Software sets an enable, a bypass select, a stability threshold and a divide ratio through a small strobe-based register port. When the oscillator is switched on, a stabilization counter counts its rising edges and raises a stable flag only after the threshold times 512 edges. Until then the oscillator is not allowed to drive anything downstream. In bypass mode an external clock pin serves as the root clock, the counter is held at zero and the flag reports stable at once.

The whole block runs on a fast system clock. Both slow inputs are treated as level signals: each passes through a synchronizer, and its edges are detected as single-cycle events. The divided output is built from the edges of the selected root: it toggles once every (ratio + 1) root edges, counting both rising and falling edges. Its period is therefore (ratio + 1) root periods and its duty cycle is 50%. A standby input can switch the oscillator off, unless a keep-alive bit allows it to stay on.

Top module: `osc_ctl_top`

## Requirements
- R1: A `wr_en_i` pulse loads the control word. The word layout is: enable in bit 0, bypass in bit 1, keep-in-standby in bit 2, divide ratio in bits 8:4 and threshold in bits 23:16. A `rd_en_i` pulse returns the current word on `rd_data_o` one clock later. The returned word also shows the stable flag in bit 3, and every other bit reads 0. Bit 3 is read-only: writes to it are ignored. After reset the word is enable=1, bypass=0, keep=1, ratio=0, threshold=4, which reads as 0x040005.
- R2: `osc_en_o` is 1 exactly when enable is 1 and either `standby_i` is 0 or keep is 1. It follows its inputs in the same cycle.
- R3: While the oscillator is enabled and not bypassed, the counter counts synchronized rising edges of `osc_clk_i` starting from zero. `osc_stable_o` rises one clock after the count reaches threshold×512. A threshold of 0 gives stable at once.
- R4: `osc_stable_o` is 0 from the clock after `osc_en_o` falls, and stays 0 while the oscillator is off. Switching the oscillator on again restarts the count from zero.
- R5: While bypass is 1, the counter is held at zero. If the oscillator is also enabled, `osc_stable_o` is 1 from the next clock.
- R6: Bypass 0 takes the root from `osc_clk_i` and bypass 1 takes it from `ext_clk_i`. Root edges reach the divider only while `osc_stable_o` is 1. Otherwise `clk_div_o` holds its level.
- R7: `clk_div_o` toggles on every (ratio+1)-th root edge, counting both edge directions. This gives a 50% duty output with a period of (ratio+1) root periods. Ratio 0 reproduces the root, and ratio 31 divides by 32.
- R8: A new ratio takes effect at the divider's next terminal count. The half-period already in progress completes at the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 24 | Control word write data |
| rd_en_i | input | 1 | Control word read strobe |
| rd_data_o | output | 24 | Read data, valid the clock after the strobe |
| standby_i | input | 1 | Chip standby mode indication |
| osc_clk_i | input | 1 | Raw slow oscillator output |
| ext_clk_i | input | 1 | External clock pin used in bypass |
| osc_en_o | output | 1 | Enable to the analog oscillator |
| osc_stable_o | output | 1 | Oscillator stable flag |
| clk_div_o | output | 1 | Divided root clock |

## Verification
The bench measures how long the oscillator takes to become stable, both from reset and after a restart. A counter that did not restart, or that used the wrong scale, would report stable thousands of cycles off the threshold×512 edge window. A ratio is rewritten in the middle of a half-period. An immediate reload would shorten that half-period and leave a runt pulse, so its length is checked against the old ratio. Standby with keep cleared, bypass with the oscillator off, and a write to the read-only status bit are each probed. In these cases a wrong gating term shows up as a stable flag or a moving output clock that should have stayed low or frozen.

// File: rtl/osc_ctl_pkg.sv
package osc_ctl_pkg;

    localparam int EOC_W    = 8;
    localparam int DIV_W    = 5;
    localparam int DATA_W   = 24;

    localparam int BIT_ON   = 0;
    localparam int BIT_BYP  = 1;
    localparam int BIT_KEEP = 2;
    localparam int BIT_STAT = 3;
    localparam int DIV_LSB  = 4;
    localparam int EOC_LSB  = 16;

    typedef struct packed {
        logic [EOC_W-1:0] eoc;
        logic [DIV_W-1:0] div;
        logic             keep;
        logic             byp;
        logic             on;
    } osc_cfg_t;

    typedef struct packed {
        logic rise;
        logic any;
    } edge_ev_t;

    function automatic osc_cfg_t word_to_cfg(input logic [DATA_W-1:0] w);
        osc_cfg_t c;
        c.on   = w[BIT_ON];
        c.byp  = w[BIT_BYP];
        c.keep = w[BIT_KEEP];
        c.div  = w[DIV_LSB +: DIV_W];
        c.eoc  = w[EOC_LSB +: EOC_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(input osc_cfg_t c, input logic stat);
        logic [DATA_W-1:0] w;
        w                   = '0;
        w[BIT_ON]           = c.on;
        w[BIT_BYP]          = c.byp;
        w[BIT_KEEP]         = c.keep;
        w[BIT_STAT]         = stat;
        w[DIV_LSB +: DIV_W] = c.div;
        w[EOC_LSB +: EOC_W] = c.eoc;
        return w;
    endfunction

endpackage

// File: rtl/osc_edge_det.sv
module osc_edge_det
    import osc_ctl_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     in_i,
    output edge_ev_t ev_o
);
    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], in_i};
    end

    always_comb begin
        ev_o.rise = sh[STAGES-1] & ~sh[STAGES];
        ev_o.any  = sh[STAGES-1] ^ sh[STAGES];
    end
endmodule

// File: rtl/osc_stab_cnt.sv
module osc_stab_cnt
    import osc_ctl_pkg::*;
#(
    parameter int SCALE_LOG2 = 9,
    localparam int CNT_W     = EOC_W + SCALE_LOG2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             byp_i,
    input  logic             rise_i,
    input  logic [EOC_W-1:0] eoc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             stable_o
);
    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] cnt_q;
    logic             hold;
    logic             reached;

    assign target  = {eoc_i, {SCALE_LOG2{1'b0}}};
    assign hold    = ~en_i | byp_i;
    assign reached = (cnt_q >= target);

    always_ff @(posedge clk) begin
        if (rst || hold)                cnt_q <= '0;
        else if (rise_i && !reached)    cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) stable_o <= 1'b0;
        else     stable_o <= en_i & (byp_i | reached);
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/osc_clk_div.sv
module osc_clk_div
    import osc_ctl_pkg::*;
#(
    parameter int DIV_RST = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             clk_o
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] act_q;
    logic             term;

    assign term = (cnt_q == act_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= DIV_W'(DIV_RST);
            clk_o <= 1'b0;
        end else if (tick_i) begin
            if (term) begin
                cnt_q <= '0;
                act_q <= div_i;
                clk_o <= ~clk_o;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/osc_ctl_top.sv
module osc_ctl_top
    import osc_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SCALE_LOG2  = 9,
    parameter int EOC_RST     = 4,
    parameter int DIV_RST     = 0,
    localparam int CNT_W      = EOC_W + SCALE_LOG2,
    localparam int N_SRC      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              standby_i,
    input  logic              osc_clk_i,
    input  logic              ext_clk_i,
    output logic              osc_en_o,
    output logic              osc_stable_o,
    output logic              clk_div_o
);
    osc_cfg_t         cfg_q;
    logic [N_SRC-1:0] src;
    edge_ev_t         ev [N_SRC];
    logic [CNT_W-1:0] stab_cnt;
    logic             root_edge;
    logic             unused_wr_bits;

    // control register
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.on   <= 1'b1;
            cfg_q.byp  <= 1'b0;
            cfg_q.keep <= 1'b1;
            cfg_q.div  <= DIV_W'(DIV_RST);
            cfg_q.eoc  <= EOC_W'(EOC_RST);
        end else if (wr_en_i) begin
            cfg_q <= word_to_cfg(wr_data_i);
        end
    end

    assign unused_wr_bits = ^{wr_data_i[BIT_STAT], wr_data_i[EOC_LSB-1:DIV_LSB+DIV_W]};

    always_ff @(posedge clk) begin
        if (rst)          rd_data_o <= '0;
        else if (rd_en_i) rd_data_o <= cfg_to_word(cfg_q, osc_stable_o);
    end

    assign osc_en_o = cfg_q.on & (~standby_i | cfg_q.keep);

    // source synchronizers: index 0 oscillator, index 1 external pin
    assign src = {ext_clk_i, osc_clk_i};

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        osc_edge_det #(.STAGES(SYNC_STAGES)) i_edge (
            .clk  (clk),
            .rst  (rst),
            .in_i (src[g]),
            .ev_o (ev[g])
        );
    end

    osc_stab_cnt #(.SCALE_LOG2(SCALE_LOG2)) i_stab (
        .clk      (clk),
        .rst      (rst),
        .en_i     (osc_en_o),
        .byp_i    (cfg_q.byp),
        .rise_i   (ev[0].rise),
        .eoc_i    (cfg_q.eoc),
        .cnt_o    (stab_cnt),
        .stable_o (osc_stable_o)
    );

    assign root_edge = osc_stable_o & (cfg_q.byp ? ev[1].any : ev[0].any);

    osc_clk_div #(.DIV_RST(DIV_RST)) i_div (
        .clk    (clk),
        .rst    (rst),
        .tick_i (root_edge),
        .div_i  (cfg_q.div),
        .clk_o  (clk_div_o)
    );
endmodule

// File: rtl/osc_ctl_chk.sv
module osc_ctl_chk
    import osc_ctl_pkg::*;
#(
    parameter int SCALE_LOG2 = 9,
    localparam int CNT_W     = EOC_W + SCALE_LOG2
) (
    input logic             clk,
    input logic             rst,
    input logic             standby_i,
    input osc_cfg_t         cfg,
    input logic             osc_en_o,
    input logic             osc_stable_o,
    input logic             clk_div_o,
    input logic             root_edge,
    input logic [CNT_W-1:0] stab_cnt
);
    // R2: standby without keep forces the enable off
    a_r2_stby_off: assert property (@(posedge clk) disable iff (rst)
        (standby_i && !cfg.keep) |-> !osc_en_o);

    // R2: outside standby the enable bit drives the oscillator on
    a_r2_run_on: assert property (@(posedge clk) disable iff (rst)
        (!standby_i && cfg.on) |-> osc_en_o);

    // R4: disable clears the stable flag at the next clock
    a_r4_off_clears: assert property (@(posedge clk) disable iff (rst)
        !osc_en_o |=> !osc_stable_o);

    // R5: enabled bypass reports stable at the next clock
    a_r5_byp_stable: assert property (@(posedge clk) disable iff (rst)
        (cfg.byp && osc_en_o) |=> osc_stable_o);

    // R5 / R4: counter held at zero in bypass or while off
    a_r5_cnt_held: assert property (@(posedge clk) disable iff (rst)
        (cfg.byp || !osc_en_o) |=> (stab_cnt == '0));

    // R3: stable rises only after the threshold was reached (or in bypass)
    a_r3_rise_gate: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_stable_o) |->
            ($past(cfg.byp) || ($past(stab_cnt) >= {$past(cfg.eoc), {SCALE_LOG2{1'b0}}})));

    // R6: no divider movement while not stable
    a_r6_freeze: assert property (@(posedge clk) disable iff (rst)
        !osc_stable_o |=> $stable(clk_div_o));

    // R7: output only toggles on a root edge
    a_r7_toggle_src: assert property (@(posedge clk) disable iff (rst)
        !$stable(clk_div_o) |-> $past(root_edge));
endmodule

bind osc_ctl_top osc_ctl_chk #(.SCALE_LOG2(SCALE_LOG2)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .standby_i    (standby_i),
    .cfg          (cfg_q),
    .osc_en_o     (osc_en_o),
    .osc_stable_o (osc_stable_o),
    .clk_div_o    (clk_div_o),
    .root_edge    (root_edge),
    .stab_cnt     (stab_cnt)
);

// File: tb/test_osc_ctl_top.sv
module test_osc_ctl_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [23:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [23:0] rdata;
    logic        standby = 1'b0;
    logic        osc = 1'b0;
    logic        ext = 1'b0;
    logic        en_o, stable_o, div_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #5 clk = ~clk;   // 100 MHz

    osc_ctl_top i_osc_ctl_top (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_data_i(wdata),
        .rd_en_i(rd_en), .rd_data_o(rdata), .standby_i(standby),
        .osc_clk_i(osc), .ext_clk_i(ext), .osc_en_o(en_o),
        .osc_stable_o(stable_o), .clk_div_o(div_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // slow clocks: oscillator period 4 cycles, external period 6 cycles
    int ocnt = 0, ecnt = 0;
    always @(negedge clk) begin
        ocnt++; ecnt++;
        if (ocnt == 2) begin osc = ~osc; ocnt = 0; end
        if (ecnt == 3) begin ext = ~ext; ecnt = 0; end
    end

    // ---------------- behavioural reference model ----------------
    bit m_on, m_byp, m_keep, m_stat, m_out;
    int m_div, m_eoc, m_cnt, m_dcnt, m_dact;
    logic [23:0] m_rd;
    bit oq[3], eq[3];

    function automatic logic [23:0] mk_word(bit on, bit byp, bit keep, int dv, int eoc, bit st);
        return 24'(on) | (24'(byp) << 1) | (24'(keep) << 2) | (24'(st) << 3)
             | (24'(dv) << 4) | (24'(eoc) << 16);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_on = 1; m_byp = 0; m_keep = 1; m_div = 0; m_eoc = 4;
            m_cnt = 0; m_stat = 0; m_dcnt = 0; m_dact = 0; m_out = 0; m_rd = '0;
            for (int i = 0; i < 3; i++) begin oq[i] = 0; eq[i] = 0; end
        end else begin
            bit en, orise, oany, eany, tick, n_stat;
            int tgt, n_cnt;
            en    = m_on && (!standby || m_keep);
            orise = oq[1] && !oq[2];
            oany  = oq[1] != oq[2];
            eany  = eq[1] != eq[2];
            tgt   = m_eoc * 512;
            if (!en || m_byp)                 n_cnt = 0;
            else if (orise && m_cnt < tgt)    n_cnt = m_cnt + 1;
            else                              n_cnt = m_cnt;
            n_stat = en && (m_byp || m_cnt >= tgt);
            tick   = m_stat && (m_byp ? eany : oany);
            if (tick) begin
                if (m_dcnt == m_dact) begin m_dcnt = 0; m_dact = m_div; m_out = !m_out; end
                else m_dcnt++;
            end
            if (rd_en) m_rd = mk_word(m_on, m_byp, m_keep, m_div, m_eoc, m_stat);
            if (wr_en) begin
                m_on = wdata[0]; m_byp = wdata[1]; m_keep = wdata[2];
                m_div = int'(wdata[8:4]); m_eoc = int'(wdata[23:16]);
            end
            m_cnt = n_cnt; m_stat = n_stat;
            oq[2] = oq[1]; oq[1] = oq[0]; oq[0] = osc;
            eq[2] = eq[1]; eq[1] = eq[0]; eq[0] = ext;
        end
        #2;
        if (!rst && !done) begin
            chk("R3 model stable", 32'(stable_o), 32'(m_stat));
            chk("R7 model clk_div", 32'(div_o), 32'(m_out));
            chk("R2 model osc_en", 32'(en_o), 32'(m_on && (!standby || m_keep)));
            chk("R1 model rd_data", 32'(rdata), 32'(m_rd));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [23:0] w);
        @(negedge clk); wr_en = 1; wdata = w;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(output logic [23:0] w);
        @(negedge clk); rd_en = 1;
        @(negedge clk); rd_en = 0; w = rdata;
    endtask

    task automatic wait_stable(output int n);
        n = 0;
        while (!stable_o && n < 20000) begin @(negedge clk); n++; end
    endtask

    task automatic wait_div(input bit lvl, output int t);
        bit last;
        last = div_o;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (div_o == lvl && last != lvl) begin t = cyc; return; end
            last = div_o;
        end
        t = -100000;
    endtask

    task automatic period(output int p);
        int t0, t1;
        wait_div(1, t0); wait_div(1, t1);
        p = t1 - t0;
    endtask

    initial begin
        logic [23:0] w;
        int n, p, t0, t1, t2;
        bit hold;
        repeat (4) @(negedge clk);
        rst = 0;

        rd(w);
        chk("R1 reset word", 32'(w), 32'h040005);

        wait_stable(n);
        chk("R3 start-up window threshold 4", 32'(n >= 8180 && n <= 8210), 1);

        period(p); period(p);
        chk("R7 ratio 0 period", 32'(p), 4);
        wr(mk_word(1, 0, 1, 2, 4, 0));
        period(p); period(p);
        chk("R7 ratio 2 period", 32'(p), 12);
        wait_div(1, t0); wait_div(0, t1);
        chk("R7 ratio 2 high time", 32'(t1 - t0), 6);
        wr(mk_word(1, 0, 1, 31, 4, 0));
        period(p); period(p);
        chk("R7 ratio 31 period", 32'(p), 128);

        wr(mk_word(1, 0, 1, 3, 4, 0));
        period(p); period(p);
        wait_div(1, t0);
        @(negedge clk);
        wr(mk_word(1, 0, 1, 1, 4, 0));
        wait_div(0, t1); wait_div(1, t2);
        chk("R8 in-flight half keeps old length", 32'(t1 - t0), 8);
        chk("R8 next half uses new ratio", 32'(t2 - t1), 4);

        wr(mk_word(0, 0, 1, 1, 4, 0));
        chk("R2 enable drops with bit", 32'(en_o), 0);
        @(negedge clk);
        chk("R4 stable clears on disable", 32'(stable_o), 0);
        hold = div_o;
        repeat (40) @(negedge clk);
        chk("R6 divider frozen while off", 32'(div_o), 32'(hold));

        wr(24'h01000C);
        rd(w);
        chk("R1 status bit read-only", 32'(w), 32'h010004);

        wr(mk_word(1, 0, 1, 0, 1, 0));
        wait_stable(n);
        chk("R4 restart window threshold 1", 32'(n >= 2040 && n <= 2064), 1);

        standby = 1;
        @(negedge clk);
        chk("R2 standby with keep stays on", 32'(en_o), 1);
        wr(mk_word(1, 0, 0, 0, 1, 0));
        chk("R2 standby without keep off", 32'(en_o), 0);
        @(negedge clk);
        chk("R4 stable cleared in standby", 32'(stable_o), 0);
        standby = 0;
        repeat (1000) @(negedge clk);
        chk("R3 recount after standby exit", 32'(stable_o), 0);
        wait_stable(n);
        chk("R3 recount completes", 32'(n >= 1000 && n <= 1100), 1);

        wr(mk_word(0, 0, 1, 0, 1, 0));
        @(negedge clk);
        wr(mk_word(1, 1, 1, 0, 1, 0));
        @(negedge clk);
        chk("R5 bypass stable at once", 32'(stable_o), 1);
        period(p); period(p);
        chk("R6 bypass root is external pin", 32'(p), 6);
        wr(mk_word(1, 1, 1, 1, 1, 0));
        period(p); period(p);
        chk("R6 bypass ratio 1 period", 32'(p), 12);
        wr(mk_word(0, 1, 1, 1, 1, 0));
        @(negedge clk);
        chk("R4 bypass but off not stable", 32'(stable_o), 0);

        wr(mk_word(1, 0, 1, 0, 0, 0));
        @(negedge clk);
        chk("R3 threshold 0 stable at once", 32'(stable_o), 1);
        repeat (20) @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule